// File: doc/BRIEF.md
# Sound Coprocessor Bus Window Controller

This block sits on a 16-bit host bus and opens a window onto the address space of an 8-bit sound coprocessor. It decodes each host request, byte or word, into one of a handful of actions: a store to or a load from the 8 KB RAM that both processors share, a status read or a port write on the FM sound chip, one step of a serially loaded bank register, a bus-request write, or a write to the coprocessor reset control.

Host stores into shared RAM are accepted only while the coprocessor is halted, either because the host holds its bus or because it is held in reset. Stores attempted while it runs are discarded, and a one-cycle anomaly pulse reports them. Reset control is edge qualified. A 0 enters the reset hold. A 1 leaves the hold only if one is pending. Entering and leaving the hold each send a one-cycle reset pulse to the FM chip.

Each request takes one cycle on the host port. Read data returns in the following cycle, because the shared RAM is read synchronously. The bank register is presented as a host-side base address.

Top module: `cop_window_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) cop_reset, cop_run, fm_reset, anomaly, hrd_valid and fm_wr_stb are all 0, and bank_base is 0.
- R2: A write to 0xA11200 whose control bit is 0 sets the reset hold from the next cycle onward: cop_reset=1 and cop_run=0. In the same next cycle fm_reset is 1 for exactly one cycle. The control bit is data bit 0 for a byte write and data bit 8 for a word write. The other data bits are ignored.
- R3: A write to 0xA11200 whose control bit is 1 clears a pending hold: cop_reset falls and fm_reset pulses for one cycle. When no hold is pending, the same write changes nothing and no pulse appears.
- R4: A write anywhere in 0xA06000–0xA060FF shifts the 9-bit bank register right by one and loads data bit 0 into its top bit. bank_base shows the register shifted left by 15. Writes outside that range, and reads inside it, leave the register unchanged.
- R5: A write to 0xA11100 takes its control bit from the same lane as R2. A 1 stops the coprocessor (cop_run=0). A 0 sets cop_run to 1 only if no reset hold is pending.
- R6: A host request whose address has bits 23:16 = 0xA0 and bit 14 = 0 targets shared RAM at address bits 12:0. While cop_run=0, a write drives ram_we in the same cycle. A byte write stores data bits 7:0. A word write stores data bits 15:8.
- R7: A shared RAM write made while cop_run=1 does not assert ram_we. anomaly is 1 for one cycle in the next cycle.
- R8: A read of shared RAM returns hrd_valid=1 in the next cycle, with the RAM byte in both halves of hrd_data.
- R9: A read with bits 23:16 = 0xA0 and bits 14:13 = 2'b10 returns the fm_status byte in both halves of hrd_data in the next cycle.
- R10: Any other read with bits 23:16 = 0xA0 returns 0xFFFF and pulses anomaly. A read outside that page returns 0xFFFF without anomaly.
- R11: A write in 0xA04000–0xA05FFF raises fm_wr_stb bit N for one cycle in the next cycle, where N is address bits 1:0. At the same time fm_wdata carries the data byte: bits 7:0 for a byte write, bits 15:8 for a word write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hreq_valid | input | 1 | Host request present this cycle |
| hreq_write | input | 1 | 1 = write, 0 = read |
| hreq_word | input | 1 | 1 = word access, 0 = byte access |
| hreq_addr | input | 24 | Host byte address |
| hreq_wdata | input | 16 | Host write data (byte writes use bits 7:0) |
| hrd_valid | output | 1 | Read response valid, one cycle after the request |
| hrd_data | output | 16 | Read response data |
| ram_addr | output | 13 | Shared RAM address |
| ram_we | output | 1 | Shared RAM write enable |
| ram_wdata | output | 8 | Shared RAM write byte |
| ram_rdata | input | 8 | Shared RAM read byte, one cycle after the address |
| fm_status | input | 8 | FM chip status byte |
| fm_wr_stb | output | 4 | One-hot FM port write strobe |
| fm_wdata | output | 8 | FM port write byte |
| fm_reset | output | 1 | One-cycle FM chip reset pulse |
| cop_reset | output | 1 | Coprocessor held in reset |
| cop_run | output | 1 | Coprocessor running (does not own its bus) |
| bank_base | output | 24 | Host base address of the 32 KB bank window |
| anomaly | output | 1 | One-cycle pulse on a dropped RAM write or an unmapped window read |

## Verification
The gate on RAM writes reads the run state in the same cycle that a host write arrives. A control write in the previous cycle can have changed that state. The bench provokes this by releasing the bus with one write and attempting a RAM store in the very next cycle. The store must not reach ram_we and must produce the anomaly pulse. A later read then confirms that the byte kept its old value. The same collision is forced with the reset hold: a bus release issued while the hold is pending must leave cop_run low. The hold must clear only on a qualifying 1, and a fm_reset pulse must appear on both edges of the hold.

// File: rtl/cop_window_pkg.sv
// Shared constants and decode types for the coprocessor bus window.
// Assumes a 24-bit host byte address bus.
package cop_window_pkg;
    localparam int HOST_AW = 24;

    localparam logic [HOST_AW-1:0] RSTCTL_ADDR = 24'hA11200;
    localparam logic [HOST_AW-1:0] BUSREQ_ADDR = 24'hA11100;
    localparam logic [7:0]         WIN_PAGE    = 8'hA0;
    localparam logic [15:0]        BANK_PAGE   = 16'hA060;
    localparam logic [1:0]         FM_REGION   = 2'b10;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RAM,
        ACC_FM,
        ACC_BANK,
        ACC_VOID,
        ACC_RSTCTL,
        ACC_BUSREQ
    } acc_kind_e;
endpackage

// File: rtl/cop_addr_decode.sv
// Classifies a host address into an access kind.
// Pure combinational logic; the caller qualifies the result with valid/write.
module cop_addr_decode
    import cop_window_pkg::*;
(
    input  logic [HOST_AW-1:0] addr,
    output acc_kind_e          kind
);
    // Priority decode: control registers first, then the window sub-regions.
    always_comb begin
        kind = ACC_NONE;
        if (addr == RSTCTL_ADDR)
            kind = ACC_RSTCTL;
        else if (addr == BUSREQ_ADDR)
            kind = ACC_BUSREQ;
        else if (addr[23:16] == WIN_PAGE) begin
            if (!addr[14])
                kind = ACC_RAM;
            else if (addr[14:13] == FM_REGION)
                kind = ACC_FM;
            else if (addr[23:8] == BANK_PAGE)
                kind = ACC_BANK;
            else
                kind = ACC_VOID;
        end
    end
endmodule

// File: rtl/cop_bank_shift.sv
// Serially loaded bank register: each load shifts right and inserts at the top.
// Assumes shift_en is a single-cycle qualified write.
module cop_bank_shift #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [BANK_W-1:0] bank
);
    // Shift one data bit into the top position per qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (shift_en)
            bank <= {din, bank[BANK_W-1:1]};
    end
endmodule

// File: rtl/cop_run_ctrl.sv
// Reset hold and run-state tracking for the coprocessor.
// Assumes rst_wr and busreq_wr are never both high; rst_wr wins if they are.
module cop_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_wr,
    input  logic busreq_wr,
    input  logic ctl_bit,
    output logic hold,
    output logic run,
    output logic fm_rst
);
    // Update hold/run and produce a one-cycle FM reset on both hold edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= 1'b0;
            run    <= 1'b0;
            fm_rst <= 1'b0;
        end else begin
            fm_rst <= 1'b0;
            if (rst_wr) begin
                if (!ctl_bit) begin
                    hold   <= 1'b1;
                    run    <= 1'b0;
                    fm_rst <= 1'b1;
                end else if (hold) begin
                    hold   <= 1'b0;
                    fm_rst <= 1'b1;
                end
            end else if (busreq_wr) begin
                run <= ctl_bit ? 1'b0 : ~hold;
            end
        end
    end
endmodule

// File: rtl/cop_window_ctrl.sv
// Top of the host-to-coprocessor bus window. Decodes host requests, gates
// shared RAM stores on the halted state, drives FM port strobes and returns
// read data one cycle after the request (the RAM is read synchronously).
// Assumes at most one host request per cycle.
module cop_window_ctrl
    import cop_window_pkg::*;
#(
    parameter int BANK_W    = 9,
    parameter int WIN_SHIFT = 15,
    parameter int RAM_AW    = 13,
    parameter int FM_PORTS  = 4,
    localparam int BASE_W   = BANK_W + WIN_SHIFT,
    localparam int FM_SEL_W = $clog2(FM_PORTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hreq_valid,
    input  logic                hreq_write,
    input  logic                hreq_word,
    input  logic [HOST_AW-1:0]  hreq_addr,
    input  logic [15:0]         hreq_wdata,
    output logic                hrd_valid,
    output logic [15:0]         hrd_data,
    output logic [RAM_AW-1:0]   ram_addr,
    output logic                ram_we,
    output logic [7:0]          ram_wdata,
    input  logic [7:0]          ram_rdata,
    input  logic [7:0]          fm_status,
    output logic [FM_PORTS-1:0] fm_wr_stb,
    output logic [7:0]          fm_wdata,
    output logic                fm_reset,
    output logic                cop_reset,
    output logic                cop_run,
    output logic [BASE_W-1:0]   bank_base,
    output logic                anomaly
);
    acc_kind_e          kind;
    acc_kind_e          rd_kind_q;
    logic               wr_req, rd_req;
    logic               ctl_bit;
    logic [7:0]         lane_byte;
    logic [BANK_W-1:0]  bank;
    logic               hold;
    logic [7:0]         fm_status_q;
    logic [FM_PORTS-1:0] stb_d;
    logic               anomaly_d;

    cop_addr_decode u_dec (
        .addr (hreq_addr),
        .kind (kind)
    );

    // Qualify the request and pick the data lane for byte or word access.
    always_comb begin
        wr_req    = hreq_valid && hreq_write;
        rd_req    = hreq_valid && !hreq_write;
        ctl_bit   = hreq_word ? hreq_wdata[8] : hreq_wdata[0];
        lane_byte = hreq_word ? hreq_wdata[15:8] : hreq_wdata[7:0];
    end

    cop_run_ctrl u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_wr    (wr_req && kind == ACC_RSTCTL),
        .busreq_wr (wr_req && kind == ACC_BUSREQ),
        .ctl_bit   (ctl_bit),
        .hold      (hold),
        .run       (cop_run),
        .fm_rst    (fm_reset)
    );

    cop_bank_shift #(.BANK_W(BANK_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (wr_req && kind == ACC_BANK),
        .din      (hreq_wdata[0]),
        .bank     (bank)
    );

    // Shared RAM port: stores only while the coprocessor is halted.
    always_comb begin
        ram_addr  = hreq_addr[RAM_AW-1:0];
        ram_wdata = lane_byte;
        ram_we    = wr_req && kind == ACC_RAM && !cop_run;
    end

    // One strobe per FM port, selected by the low address bits.
    for (genvar p = 0; p < FM_PORTS; p++) begin : g_fm_stb
        assign stb_d[p] = wr_req && kind == ACC_FM &&
                          hreq_addr[FM_SEL_W-1:0] == FM_SEL_W'(p);
    end

    // Anomaly: dropped RAM store or a read of an unmapped window slot.
    always_comb begin
        anomaly_d = (wr_req && kind == ACC_RAM && cop_run) ||
                    (rd_req && (kind == ACC_VOID || kind == ACC_BANK));
    end

    // Register responses, strobes and flags for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hrd_valid   <= 1'b0;
            rd_kind_q   <= ACC_NONE;
            fm_status_q <= '0;
            fm_wr_stb   <= '0;
            fm_wdata    <= '0;
            anomaly     <= 1'b0;
        end else begin
            hrd_valid   <= rd_req;
            rd_kind_q   <= rd_req ? kind : ACC_NONE;
            fm_status_q <= fm_status;
            fm_wr_stb   <= stb_d;
            if (|stb_d)
                fm_wdata <= lane_byte;
            anomaly     <= anomaly_d;
        end
    end

    // Read data mux: RAM and FM status duplicated into both byte lanes.
    always_comb begin
        case (rd_kind_q)
            ACC_RAM: hrd_data = {ram_rdata, ram_rdata};
            ACC_FM:  hrd_data = {fm_status_q, fm_status_q};
            default: hrd_data = 16'hFFFF;
        endcase
    end

    assign cop_reset = hold;
    assign bank_base = {bank, {WIN_SHIFT{1'b0}}};
endmodule

// File: rtl/cop_window_chk.sv
// Property checker for cop_window_ctrl, attached with bind below.
// Watches ports only; re-derives the bank page hit from the address.
module cop_window_chk #(
    parameter int BANK_W    = 9,
    parameter int WIN_SHIFT = 15,
    parameter int FM_PORTS  = 4,
    localparam int BASE_W   = BANK_W + WIN_SHIFT
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hreq_valid,
    input logic                hreq_write,
    input logic [23:0]         hreq_addr,
    input logic [15:0]         hreq_wdata,
    input logic                hrd_valid,
    input logic                ram_we,
    input logic [FM_PORTS-1:0] fm_wr_stb,
    input logic                fm_reset,
    input logic                cop_reset,
    input logic                cop_run,
    input logic [BASE_W-1:0]   bank_base
);
    // R2
    hold_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_reset |-> !cop_run);

    // R3
    fm_pulse_on_hold_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cop_reset) || $fell(cop_reset)) |-> fm_reset);

    // R4
    bank_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hreq_valid && hreq_write && hreq_addr[23:8] == 16'hA060) |=>
        (bank_base[BASE_W-1] == $past(hreq_wdata[0]) &&
         bank_base[BASE_W-2:WIN_SHIFT] == $past(bank_base[BASE_W-1:WIN_SHIFT+1])));

    // R7
    ram_we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !cop_run);

    // R8
    read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hreq_valid && !hreq_write) |=> hrd_valid);

    // R11
    fm_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fm_wr_stb));

    // R11
    fm_strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fm_wr_stb) |-> $past(hreq_valid && hreq_write));
endmodule

bind cop_window_ctrl cop_window_chk #(
    .BANK_W    (BANK_W),
    .WIN_SHIFT (WIN_SHIFT),
    .FM_PORTS  (FM_PORTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hreq_valid (hreq_valid),
    .hreq_write (hreq_write),
    .hreq_addr  (hreq_addr),
    .hreq_wdata (hreq_wdata),
    .hrd_valid  (hrd_valid),
    .ram_we     (ram_we),
    .fm_wr_stb  (fm_wr_stb),
    .fm_reset   (fm_reset),
    .cop_reset  (cop_reset),
    .cop_run    (cop_run),
    .bank_base  (bank_base)
);

// File: tb/test_cop_window_ctrl.sv
// Directed bench for cop_window_ctrl: one task per scenario.
module test_cop_window_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hreq_valid = 1'b0;
    logic        hreq_write = 1'b0;
    logic        hreq_word = 1'b0;
    logic [23:0] hreq_addr = '0;
    logic [15:0] hreq_wdata = '0;
    logic        hrd_valid;
    logic [15:0] hrd_data;
    logic [12:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  fm_status = 8'h81;
    logic [3:0]  fm_wr_stb;
    logic [7:0]  fm_wdata;
    logic        fm_reset;
    logic        cop_reset;
    logic        cop_run;
    logic [23:0] bank_base;
    logic        anomaly;

    int n_tests = 0;
    int n_fail  = 0;

    // Values captured by the access task
    logic        c_we;
    logic [12:0] c_waddr;
    logic [7:0]  c_wdata;
    logic        c_rv, c_an, c_frst;
    logic [15:0] c_rd;
    logic [3:0]  c_stb;
    logic [7:0]  c_fd;

    logic [7:0]  mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_window_ctrl i_cop_window_ctrl (
        .clk(clk), .rst_n(rst_n),
        .hreq_valid(hreq_valid), .hreq_write(hreq_write), .hreq_word(hreq_word),
        .hreq_addr(hreq_addr), .hreq_wdata(hreq_wdata),
        .hrd_valid(hrd_valid), .hrd_data(hrd_data),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .fm_status(fm_status), .fm_wr_stb(fm_wr_stb), .fm_wdata(fm_wdata),
        .fm_reset(fm_reset), .cop_reset(cop_reset), .cop_run(cop_run),
        .bank_base(bank_base), .anomaly(anomaly)
    );

    // Synchronous shared RAM model (low 8 address bits only).
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
        ram_rdata <= mem[ram_addr[7:0]];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One host request; captures comb RAM port and next-cycle outputs.
    task automatic access(input logic wr, input logic wd, input logic [23:0] a,
                          input logic [15:0] d);
        @(negedge clk);
        hreq_valid = 1'b1; hreq_write = wr; hreq_word = wd;
        hreq_addr = a; hreq_wdata = d;
        #1;
        c_we = ram_we; c_waddr = ram_addr; c_wdata = ram_wdata;
        @(posedge clk); #1;
        c_rv = hrd_valid; c_rd = hrd_data; c_an = anomaly;
        c_stb = fm_wr_stb; c_fd = fm_wdata; c_frst = fm_reset;
        hreq_valid = 1'b0; hreq_write = 1'b0;
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R1 cop_reset", cop_reset, 0);
        chk("R1 cop_run", cop_run, 0);
        chk("R1 bank_base", bank_base, 0);
        chk("R1 hrd_valid", hrd_valid, 0);
        chk("R1 fm_reset", fm_reset, 0);
        chk("R1 fm_wr_stb", fm_wr_stb, 0);
        chk("R1 anomaly", anomaly, 0);
    endtask

    task automatic t_ram();
        access(1, 0, 24'hA00005, 16'hEE5A);
        chk("R6 byte we", c_we, 1);
        chk("R6 byte data", c_wdata, 8'h5A);
        chk("R6 byte addr", c_waddr, 13'h0005);
        access(0, 0, 24'hA00005, 16'h0000);
        chk("R8 byte read valid", c_rv, 1);
        chk("R8 byte read data", c_rd, 16'h5A5A);
        access(1, 1, 24'hA01012, 16'hC377);
        chk("R6 word we", c_we, 1);
        chk("R6 word upper byte", c_wdata, 8'hC3);
        chk("R6 word addr", c_waddr, 13'h1012);
        access(0, 1, 24'hA01012, 16'h0000);
        chk("R8 word read data", c_rd, 16'hC3C3);
    endtask

    task automatic t_busreq();
        access(1, 0, 24'hA11100, 16'h00FE);
        chk("R5 release runs", cop_run, 1);
        // store in the very next cycle must be dropped
        access(1, 0, 24'hA00005, 16'h0011);
        chk("R7 dropped no we", c_we, 0);
        chk("R7 anomaly", c_an, 1);
        access(0, 0, 24'hA00005, 16'h0000);
        chk("R7 RAM unchanged", c_rd, 16'h5A5A);
        chk("R8 read while running no anomaly", c_an, 0);
        access(1, 1, 24'hA11100, 16'h0100);
        chk("R5 word request stops", cop_run, 0);
    endtask

    task automatic t_reset_ctrl();
        access(1, 0, 24'hA11200, 16'h0001);
        chk("R3 no hold no pulse", c_frst, 0);
        chk("R3 no hold cop_reset", cop_reset, 0);
        access(1, 1, 24'hA11100, 16'h0000);
        chk("R5 running before hold", cop_run, 1);
        access(1, 0, 24'hA11200, 16'hFF00);
        chk("R2 hold set", cop_reset, 1);
        chk("R2 run cleared", cop_run, 0);
        chk("R2 fm pulse", c_frst, 1);
        idle_cycle();
        chk("R2 fm pulse one cycle", fm_reset, 0);
        access(1, 1, 24'hA11100, 16'h0000);
        chk("R5 release blocked by hold", cop_run, 0);
        access(1, 1, 24'hA11200, 16'h0100);
        chk("R3 hold cleared", cop_reset, 0);
        chk("R3 release pulse", c_frst, 1);
        idle_cycle();
        chk("R3 release pulse one cycle", fm_reset, 0);
        access(1, 1, 24'hA11200, 16'h00FF);
        chk("R2 word lane bit8", cop_reset, 1);
        access(1, 1, 24'hA11200, 16'h0100);
        chk("R3 word release", cop_reset, 0);
        access(1, 1, 24'hA11200, 16'h0100);
        chk("R3 repeat release no pulse", c_frst, 0);
    endtask

    task automatic t_bank();
        logic [8:0] exp_bank = '0;
        logic [8:0] bits = 9'b1_0100_1101;
        for (int i = 0; i < 9; i++) begin
            access(1, i[0], (i[1] ? 24'hA060FF : 24'hA06000), {15'h7F0F, bits[i]});
            exp_bank = {bits[i], exp_bank[8:1]};
            chk("R4 bank shift", bank_base, {exp_bank, 15'h0});
        end
        access(1, 0, 24'hA06100, 16'h0001);
        chk("R4 outside range no shift", bank_base, {exp_bank, 15'h0});
        access(0, 0, 24'hA06000, 16'h0000);
        chk("R4 read no shift", bank_base, {exp_bank, 15'h0});
        chk("R10 bank page read data", c_rd, 16'hFFFF);
        chk("R10 bank page read anomaly", c_an, 1);
    endtask

    task automatic t_fm();
        access(0, 0, 24'hA04000, 16'h0000);
        chk("R9 status read", c_rd, 16'h8181);
        fm_status = 8'h3C;
        access(0, 1, 24'hA05F02, 16'h0000);
        chk("R9 status read 2", c_rd, 16'h3C3C);
        access(1, 0, 24'hA04002, 16'hAA33);
        chk("R11 strobe port2", c_stb, 4'b0100);
        chk("R11 byte data", c_fd, 8'h33);
        idle_cycle();
        chk("R11 strobe one cycle", fm_wr_stb, 4'b0000);
        access(1, 1, 24'hA05001, 16'h9900);
        chk("R11 strobe port1", c_stb, 4'b0010);
        chk("R11 word data", c_fd, 8'h99);
    endtask

    task automatic t_unmapped();
        access(0, 1, 24'hA0E000, 16'h0000);
        chk("R10 unmapped data", c_rd, 16'hFFFF);
        chk("R10 unmapped anomaly", c_an, 1);
        access(0, 1, 24'hB00000, 16'h0000);
        chk("R10 outside page data", c_rd, 16'hFFFF);
        chk("R10 outside page no anomaly", c_an, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle_cycle();
        t_ram();
        t_busreq();
        t_reset_ctrl();
        t_bank();
        t_fm();
        t_unmapped();
        repeat (2) idle_cycle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule